// File: doc/BRIEF.md
# I2C Slave with Masked Address Matching

This block is the target side of a two-wire serial bus. A fast system clock oversamples the open-drain clock and data lines. Each line passes through a synchroniser before use. From the filtered lines the block finds Start and Stop conditions, collects bytes MSB first, and decides whether the first byte of a transfer selects it. The address check uses a programmable mask, so a single device can answer a group of addresses. The block handles 7-bit addresses, 10-bit addresses sent as a header byte plus a low byte, and the all-zero broadcast address.

Received bytes are assembled in a shift register and then copied into a holding buffer that the host reads. Bytes to send use a single buffer: a host write fills the holding buffer and the shift register together. When a controller asks to read, the block holds the clock line low until the host has supplied a byte. Host access is a small register port: holding buffer, own address, mask, control and status. One interrupt line follows a status flag.

Register offsets (8-bit registers): 0 buffer, 1 own address bits 7:0, 2 own address bits 9:8 (in bits 1:0), 3 mask bits 7:0, 4 mask bits 9:8 (in bits 1:0), 5 control, 6 status. Control bits: 0 enable, 1 ten-bit mode, 2 broadcast enable. Status bits: 0 buffer full, 1 transmit mode, 2 last byte was data, 3 Start seen, 4 Stop seen, 5 broadcast matched, 6 overflow, 7 interrupt flag.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, both line drivers are off, irq is 0, status reads 0x00, the mask registers read all ones and control reads 0.
- R2: When enabled, a falling SDA while SCL is high sets status bit 3 and clears bit 4. A rising SDA while SCL is high sets bit 4 and clears bit 3.
- R3: In 7-bit mode, an address byte whose bits 7:1 equal own address bits 6:0 is acknowledged (SDA pulled low during the ninth clock) and sets the interrupt flag. A non-matching address is not acknowledged, and the block ignores the bus until the next Start.
- R4: An own-address bit whose mask bit is 0 does not take part in the comparison. A mask bit of 1 makes the address bit take part.
- R5: The address byte 0x00 is acknowledged as a write, and sets status bit 5, only when control bit 2 is 1.
- R6: In 10-bit mode, a header byte 11110 a9 a8 0 that matches (under the mask) is acknowledged, followed by a low byte that matches own address bits 7:0. A non-matching low byte is not acknowledged. After a full match, a repeated Start followed by the header with R/W=1 is acknowledged and starts transmit.
- R7: A received data byte taken while the buffer is empty is acknowledged, copied to the buffer, and sets status bit 0 and the interrupt flag. A host read of offset 0 returns the byte and clears bit 0.
- R8: A data byte that completes while status bit 0 is still 1 is not acknowledged. It leaves the buffer unchanged and sets status bit 6.
- R9: After an acknowledged address with R/W=1, the block holds SCL low until the host writes offset 0. It then sends that byte MSB first.
- R10: During transmit, a controller ACK with the buffer empty makes the block hold SCL again until the next write. A controller NACK makes it release SDA and stay quiet.
- R11: Host writes to status change only bits 7:6. Bits 5:0 keep their values. irq equals status bit 7.
- R12: With control bit 0 at 0, the block never drives either line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rd | input | 1 | Register read strobe (clears buffer full on offset 0) |
| host_rdata | output | 8 | Register read data for host_addr |
| irq | output | 1 | Interrupt, follows status bit 7 |

## Verification
Address matching is tried with an exact 7-bit hit, a single-bit miss, and two addresses under a partial mask. One of these differs only in masked bits, the other in a compared bit, which separates the masked and unmasked parts of the comparison. The broadcast address is sent with the enable off and on. The 10-bit path is tried with a correct and a wrong low byte, then with a repeated-Start read. Together these tell the header match apart from the low-byte match. Data is tried as single bytes, as back-to-back bytes with no host read between them (overflow), and as transmitted bytes with asymmetric bit patterns that would show a wrong shift order.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

   typedef enum logic [2:0] {
      SL_IDLE,
      SL_ADDR,
      SL_RX,
      SL_ACK,
      SL_TX,
      SL_MACK,
      SL_HOLD
   } slv_state_t;

   localparam logic [2:0] RA_BUF  = 3'd0;
   localparam logic [2:0] RA_OWNL = 3'd1;
   localparam logic [2:0] RA_OWNH = 3'd2;
   localparam logic [2:0] RA_MSKL = 3'd3;
   localparam logic [2:0] RA_MSKH = 3'd4;
   localparam logic [2:0] RA_CTRL = 3'd5;
   localparam logic [2:0] RA_STAT = 3'd6;

   localparam int CB_EN  = 0;
   localparam int CB_TEN = 1;
   localparam int CB_GC  = 2;
   localparam int CTRL_W = 3;

   localparam int SB_OV = 6;
   localparam int SB_IF = 7;

   localparam logic [4:0] TEN_TAG = 5'b11110;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_h,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_filter: STAGES must be at least 2");
      end
   endgenerate

   // bit 0 = SCL, bit 1 = SDA; index STAGES is the history copy
   logic [STAGES:0][1:0] pipe_q;
   logic [1:0]           cur;
   logic [1:0]           prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], {sda_raw, scl_raw}};
   end

   assign cur      = pipe_q[STAGES-1];
   assign prv      = pipe_q[STAGES];
   assign sda_h    = cur[1];
   assign scl_rise = cur[0] & ~prv[0];
   assign scl_fall = ~cur[0] & prv[0];
   assign start_p  = cur[0] & prv[0] & prv[1] & ~cur[1];
   assign stop_p   = cur[0] & prv[0] & ~prv[1] & cur[1];

endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10
) (
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [ADDR_W-1:0] own,
   input  logic [ADDR_W-1:0] mask,
   input  logic              gc_en,
   output logic              hit7,
   output logic              hit_hdr,
   output logic              hit_lo,
   output logic              hit_gc
);
   import i2c_slv_pkg::*;

   localparam int HDR_W = ADDR_W - DATA_W;

   generate
      if (DATA_W != 8 || HDR_W != 2) begin : g_bad_widths
         $error("i2c_addr_cmp: byte must be 8 bits and address 10 bits");
      end
   endgenerate

   // mask bit 1 = compared, 0 = don't care
   assign hit7    = ((rx_byte[DATA_W-1:1] ^ own[DATA_W-2:0]) & mask[DATA_W-2:0]) == '0;
   assign hit_hdr = (rx_byte[DATA_W-1:HDR_W+1] == TEN_TAG) &&
                    (((rx_byte[HDR_W:1] ^ own[ADDR_W-1:DATA_W]) & mask[ADDR_W-1:DATA_W]) == '0);
   assign hit_lo  = ((rx_byte ^ own[DATA_W-1:0]) & mask[DATA_W-1:0]) == '0;
   assign hit_gc  = gc_en && (rx_byte == '0);

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 10,
   parameter int REG_AW      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [REG_AW-1:0] host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq
);
   import i2c_slv_pkg::*;

   localparam int HDR_W = ADDR_W - DATA_W;
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

   generate
      if (REG_AW != 3) begin : g_bad_reg_aw
         $error("i2c_addr_slave: REG_AW must be 3");
      end
      if (HDR_W < 1) begin : g_bad_addr_w
         $error("i2c_addr_slave: ADDR_W must exceed DATA_W");
      end
   endgenerate

   logic sda_h, scl_rise, scl_fall, start_p, stop_p;
   logic hit7, hit_hdr, hit_lo, hit_gc;

   logic [ADDR_W-1:0] own_q, mask_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] hold_q, sh_q;
   logic [CNT_W-1:0]  cnt_q;
   slv_state_t        st_q, nxt_q;
   logic ack_q, ack_on_q, lo_q, hi_ok_q, tx_full_q, mack_q;
   logic sda_low_q, scl_low_q;
   logic bf_q, rw_q, da_q, s_q, p_q, gc_q, ov_q, if_q;
   logic [DATA_W-1:0] rx_byte_w, stat_w;
   logic en_w;

   i2c_line_filter #(.STAGES(SYNC_STAGES)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_raw  (scl_i),
      .sda_raw  (sda_i),
      .sda_h    (sda_h),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   assign rx_byte_w = {sh_q[DATA_W-2:0], sda_h};

   i2c_addr_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
      .rx_byte (rx_byte_w),
      .own     (own_q),
      .mask    (mask_q),
      .gc_en   (ctrl_q[CB_GC]),
      .hit7    (hit7),
      .hit_hdr (hit_hdr),
      .hit_lo  (hit_lo),
      .hit_gc  (hit_gc)
   );

   assign en_w   = ctrl_q[CB_EN];
   assign stat_w = {if_q, ov_q, gc_q, p_q, s_q, da_q, rw_q, bf_q};
   assign scl_oe = scl_low_q;
   assign sda_oe = sda_low_q;
   assign irq    = if_q;

   always_comb begin
      case (host_addr)
         RA_BUF:  host_rdata = hold_q;
         RA_OWNL: host_rdata = own_q[DATA_W-1:0];
         RA_OWNH: host_rdata = {{(2*DATA_W-ADDR_W){1'b0}}, own_q[ADDR_W-1:DATA_W]};
         RA_MSKL: host_rdata = mask_q[DATA_W-1:0];
         RA_MSKH: host_rdata = {{(2*DATA_W-ADDR_W){1'b0}}, mask_q[ADDR_W-1:DATA_W]};
         RA_CTRL: host_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
         RA_STAT: host_rdata = stat_w;
         default: host_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q     <= '0;
         mask_q    <= '1;
         ctrl_q    <= '0;
         hold_q    <= '0;
         sh_q      <= '0;
         cnt_q     <= '0;
         st_q      <= SL_IDLE;
         nxt_q     <= SL_IDLE;
         ack_q     <= 1'b0;
         ack_on_q  <= 1'b0;
         lo_q      <= 1'b0;
         hi_ok_q   <= 1'b0;
         tx_full_q <= 1'b0;
         mack_q    <= 1'b0;
         sda_low_q <= 1'b0;
         scl_low_q <= 1'b0;
         bf_q      <= 1'b0;
         rw_q      <= 1'b0;
         da_q      <= 1'b0;
         s_q       <= 1'b0;
         p_q       <= 1'b0;
         gc_q      <= 1'b0;
         ov_q      <= 1'b0;
         if_q      <= 1'b0;
      end else begin
         // host side
         if (host_wr) begin
            case (host_addr)
               RA_BUF:  begin hold_q <= host_wdata; sh_q <= host_wdata; tx_full_q <= 1'b1; end
               RA_OWNL: own_q[DATA_W-1:0]       <= host_wdata;
               RA_OWNH: own_q[ADDR_W-1:DATA_W]  <= host_wdata[HDR_W-1:0];
               RA_MSKL: mask_q[DATA_W-1:0]      <= host_wdata;
               RA_MSKH: mask_q[ADDR_W-1:DATA_W] <= host_wdata[HDR_W-1:0];
               RA_CTRL: ctrl_q <= host_wdata[CTRL_W-1:0];
               RA_STAT: begin ov_q <= host_wdata[SB_OV]; if_q <= host_wdata[SB_IF]; end
               default: ;
            endcase
         end
         if (host_rd && host_addr == RA_BUF) bf_q <= 1'b0;

         // bus side
         if (!en_w) begin
            st_q      <= SL_IDLE;
            sda_low_q <= 1'b0;
            scl_low_q <= 1'b0;
         end else if (start_p) begin
            st_q      <= SL_ADDR;
            cnt_q     <= '0;
            lo_q      <= 1'b0;
            sda_low_q <= 1'b0;
            scl_low_q <= 1'b0;
            s_q       <= 1'b1;
            p_q       <= 1'b0;
         end else if (stop_p) begin
            st_q      <= SL_IDLE;
            sda_low_q <= 1'b0;
            scl_low_q <= 1'b0;
            s_q       <= 1'b0;
            p_q       <= 1'b1;
            hi_ok_q   <= 1'b0;
            tx_full_q <= 1'b0;
            rw_q      <= 1'b0;
         end else begin
            case (st_q)
               SL_ADDR, SL_RX: begin
                  if (scl_rise) begin
                     sh_q <= rx_byte_w;
                     if (cnt_q != LAST_BIT) begin
                        cnt_q <= cnt_q + 1'b1;
                     end else begin
                        cnt_q    <= '0;
                        st_q     <= SL_ACK;
                        ack_on_q <= 1'b0;
                        if (st_q == SL_RX) begin
                           da_q <= 1'b1;
                           if (bf_q) begin
                              ov_q  <= 1'b1;
                              ack_q <= 1'b0;
                           end else begin
                              hold_q <= rx_byte_w;
                              bf_q   <= 1'b1;
                              if_q   <= 1'b1;
                              ack_q  <= 1'b1;
                              nxt_q  <= SL_RX;
                           end
                        end else begin
                           da_q <= 1'b0;
                           if (hit_gc && !lo_q) begin
                              ack_q <= 1'b1; nxt_q <= SL_RX; gc_q <= 1'b1;
                              if_q  <= 1'b1; rw_q  <= 1'b0;
                           end else if (!ctrl_q[CB_TEN]) begin
                              ack_q <= hit7;
                              if (hit7) begin
                                 gc_q  <= 1'b0;
                                 if_q  <= 1'b1;
                                 rw_q  <= rx_byte_w[0];
                                 nxt_q <= rx_byte_w[0] ? SL_HOLD : SL_RX;
                              end
                           end else if (lo_q) begin
                              ack_q   <= hit_lo;
                              hi_ok_q <= hit_lo;
                              lo_q    <= 1'b0;
                              if (hit_lo) begin
                                 gc_q <= 1'b0; if_q <= 1'b1; nxt_q <= SL_RX;
                              end
                           end else if (hit_hdr && !rx_byte_w[0]) begin
                              ack_q <= 1'b1; lo_q <= 1'b1; nxt_q <= SL_ADDR;
                           end else if (hit_hdr && hi_ok_q) begin
                              ack_q <= 1'b1; rw_q <= 1'b1; if_q <= 1'b1;
                              gc_q  <= 1'b0; nxt_q <= SL_HOLD;
                           end else begin
                              ack_q   <= 1'b0;
                              hi_ok_q <= 1'b0;
                           end
                        end
                     end
                  end
               end
               SL_ACK: begin
                  if (scl_fall) begin
                     if (!ack_on_q) begin
                        ack_on_q  <= 1'b1;
                        sda_low_q <= ack_q;
                     end else begin
                        sda_low_q <= 1'b0;
                        cnt_q     <= '0;
                        if (!ack_q) begin
                           st_q <= SL_IDLE;
                        end else if (nxt_q == SL_HOLD) begin
                           if (tx_full_q) begin
                              st_q      <= SL_TX;
                              sh_q      <= hold_q;
                              sda_low_q <= ~hold_q[DATA_W-1];
                              tx_full_q <= 1'b0;
                           end else begin
                              st_q      <= SL_HOLD;
                              scl_low_q <= 1'b1;
                              ack_on_q  <= 1'b0;
                           end
                        end else begin
                           st_q <= nxt_q;
                        end
                     end
                  end
               end
               SL_HOLD: begin
                  // place the first bit, then free SCL one cycle later
                  if (ack_on_q) begin
                     scl_low_q <= 1'b0;
                     st_q      <= SL_TX;
                     cnt_q     <= '0;
                  end else if (tx_full_q) begin
                     sh_q      <= hold_q;
                     sda_low_q <= ~hold_q[DATA_W-1];
                     tx_full_q <= 1'b0;
                     ack_on_q  <= 1'b1;
                  end
               end
               SL_TX: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt_q == ALL_BITS) begin
                        sda_low_q <= 1'b0;
                        st_q      <= SL_MACK;
                     end else begin
                        sh_q      <= {sh_q[DATA_W-2:0], 1'b0};
                        sda_low_q <= ~sh_q[DATA_W-2];
                     end
                  end
               end
               SL_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_h;
                  end else if (scl_fall) begin
                     cnt_q <= '0;
                     if (!mack_q) begin
                        st_q <= SL_IDLE;
                     end else begin
                        if_q <= 1'b1;
                        if (tx_full_q) begin
                           st_q      <= SL_TX;
                           sh_q      <= hold_q;
                           sda_low_q <= ~hold_q[DATA_W-1];
                           tx_full_q <= 1'b0;
                        end else begin
                           st_q      <= SL_HOLD;
                           scl_low_q <= 1'b1;
                           ack_on_q  <= 1'b0;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_p,
   input logic              en,
   input logic              s_bit,
   input logic              p_bit,
   input logic              sda_oe,
   input logic              scl_oe,
   input logic              rw_bit,
   input logic              bf,
   input logic              host_wr,
   input logic [DATA_W-1:0] hold
);

   // R2
   start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_p && en) |=> (s_bit && !p_bit));

   // R12
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> (!sda_oe && !scl_oe));

   // R9
   stretch_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> rw_bit);

   // R8
   full_buf_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bf && $past(bf) && !$past(host_wr)) |-> $stable(hold));

endmodule

bind i2c_addr_slave i2c_addr_slave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_p (start_p),
   .en      (en_w),
   .s_bit   (s_q),
   .p_bit   (p_q),
   .sda_oe  (sda_oe),
   .scl_oe  (scl_oe),
   .rw_bit  (rw_q),
   .bf      (bf_q),
   .host_wr (host_wr),
   .hold    (hold_q)
);

// File: tb/test_i2c_addr_slave.sv
module test_i2c_addr_slave;

   localparam int CLK_PERIOD = 10;
   localparam int H          = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl_dn = 1'b0;
   logic m_sda_dn = 1'b0;
   logic scl_line, sda_line;
   logic scl_oe, sda_oe, irq;
   logic [2:0] host_addr = '0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_line = !(m_scl_dn || scl_oe);
   assign sda_line = !(m_sda_dn || sda_oe);

   i2c_addr_slave i_i2c_addr_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_line),
      .sda_i      (sda_line),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rd    (host_rd),
      .host_rdata (host_rdata),
      .irq        (irq)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic bus_start;
      m_sda_dn = 1'b0; tick(H);
      m_scl_dn = 1'b0; wait (scl_line == 1'b1); tick(H);
      m_sda_dn = 1'b1; tick(H);
      m_scl_dn = 1'b1; tick(H);
   endtask

   task automatic bus_stop;
      m_sda_dn = 1'b1; tick(H);
      m_scl_dn = 1'b0; wait (scl_line == 1'b1); tick(H);
      m_sda_dn = 1'b0; tick(H);
   endtask

   task automatic send_bit(logic b);
      m_sda_dn = !b; tick(H);
      m_scl_dn = 1'b0; wait (scl_line == 1'b1); tick(H);
      m_scl_dn = 1'b1; tick(2);
   endtask

   task automatic recv_bit(output logic b);
      m_sda_dn = 1'b0; tick(H);
      m_scl_dn = 1'b0; wait (scl_line == 1'b1); tick(H/2);
      b = sda_line; tick(H/2);
      m_scl_dn = 1'b1; tick(2);
   endtask

   task automatic write_byte(logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      acked = !a;
   endtask

   task automatic read_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(!give_ack);
   endtask

   // scoreboard: driver side pushes, host side pops and compares
   task automatic drive_data(logic [7:0] v, string req);
      logic ak;
      write_byte(v, ak);
      check(req, ak, 1);
      exp_q.push_back(v);
   endtask

   task automatic drain(string req);
      logic [7:0] d;
      int e;
      reg_rd(3'd0, d);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
      check(req, d, e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, s0, b;
      logic ak;
      tick(5);
      rst_n = 1'b1;
      tick(3);

      // R1 reset state
      check("R1 sda_oe", sda_oe, 0);
      check("R1 scl_oe", scl_oe, 0);
      check("R1 irq", irq, 0);
      reg_rd(3'd6, d); check("R1 status", d, 8'h00);
      reg_rd(3'd3, d); check("R1 mask lo", d, 8'hFF);
      reg_rd(3'd4, d); check("R1 mask hi", d, 8'h03);
      reg_rd(3'd5, d); check("R1 control", d, 8'h00);

      reg_wr(3'd1, 8'h50);
      reg_wr(3'd5, 8'h01);

      // R2 start / stop flags
      bus_start;
      reg_rd(3'd6, d); check("R2 S after start", d[4:3], 2'b01);
      bus_stop;
      reg_rd(3'd6, d); check("R2 P after stop", d[4:3], 2'b10);

      // R3 + R7 write one byte
      bus_start;
      write_byte(8'hA0, ak); check("R3 match ack", ak, 1);
      check("R3 irq on match", irq, 1);
      reg_wr(3'd6, 8'h00);
      drive_data(8'h3C, "R7 data ack");
      reg_rd(3'd6, d); check("R7 buffer full", d[0], 1);
      check("R7 irq on byte", irq, 1);
      bus_stop;
      drain("R7 buffer value");
      reg_rd(3'd6, d); check("R7 full cleared by read", d[0], 0);
      reg_wr(3'd6, 8'h00);

      // R3 mismatch, following byte ignored
      bus_start;
      write_byte(8'hA2, ak); check("R3 miss nack", ak, 0);
      write_byte(8'h11, ak); check("R3 ignored after miss", ak, 0);
      reg_rd(3'd6, d); check("R3 nothing stored", d[0], 0);
      bus_stop;

      // R8 overflow
      bus_start;
      write_byte(8'hA0, ak); check("R8 addr ack", ak, 1);
      drive_data(8'h5A, "R8 first byte ack");
      write_byte(8'hC3, ak); check("R8 second byte nack", ak, 0);
      reg_rd(3'd6, d); check("R8 overflow bit", d[6], 1);
      bus_stop;
      drain("R8 buffer kept");
      reg_wr(3'd6, 8'h00);

      // R4 mask: low two bits ignored
      reg_wr(3'd3, 8'h7C);
      bus_start; write_byte(8'hA6, ak); check("R4 masked bits differ ack", ak, 1); bus_stop;
      bus_start; write_byte(8'hB0, ak); check("R4 compared bit differs nack", ak, 0); bus_stop;
      reg_wr(3'd3, 8'hFF);

      // R5 broadcast
      bus_start; write_byte(8'h00, ak); check("R5 disabled nack", ak, 0); bus_stop;
      reg_wr(3'd5, 8'h05);
      bus_start;
      write_byte(8'h00, ak); check("R5 enabled ack", ak, 1);
      reg_rd(3'd6, d); check("R5 status bit", d[5], 1);
      drive_data(8'h77, "R5 data ack");
      bus_stop;
      drain("R5 buffer value");
      reg_wr(3'd6, 8'h00);

      // R6 10-bit, own 0x2A5
      reg_wr(3'd1, 8'hA5);
      reg_wr(3'd2, 8'h02);
      reg_wr(3'd5, 8'h03);
      bus_start;
      write_byte(8'hF4, ak); check("R6 header ack", ak, 1);
      write_byte(8'hA5, ak); check("R6 low ack", ak, 1);
      drive_data(8'h99, "R6 data ack");
      bus_stop;
      drain("R6 buffer value");
      bus_start;
      write_byte(8'hF4, ak); check("R6 header ack 2", ak, 1);
      write_byte(8'hA4, ak); check("R6 wrong low nack", ak, 0);
      bus_stop;
      reg_wr(3'd6, 8'h00);
      bus_start;
      write_byte(8'hF4, ak); check("R6 header ack 3", ak, 1);
      write_byte(8'hA5, ak); check("R6 low ack 3", ak, 1);
      bus_start;
      write_byte(8'hF5, ak); check("R6 read header ack", ak, 1);
      fork
         read_byte(b, 1'b0);
         begin
            wait (scl_oe == 1'b1);
            tick(10);
            reg_wr(3'd0, 8'h6E);
         end
      join
      check("R6 tx byte", b, 8'h6E);
      bus_stop;
      reg_wr(3'd6, 8'h00);

      // R9 / R10 7-bit read with stretch
      reg_wr(3'd1, 8'h50);
      reg_wr(3'd2, 8'h00);
      reg_wr(3'd5, 8'h01);
      bus_start;
      write_byte(8'hA1, ak); check("R9 read addr ack", ak, 1);
      fork
         read_byte(b, 1'b1);
         begin
            wait (scl_oe == 1'b1);
            tick(60);
            check("R9 SCL held low", scl_line, 0);
            reg_wr(3'd0, 8'h96);
         end
      join
      check("R9 tx msb first", b, 8'h96);
      fork
         read_byte(b, 1'b0);
         begin
            wait (scl_oe == 1'b1);
            tick(40);
            check("R10 held again after ack", scl_line, 0);
            reg_wr(3'd0, 8'h0F);
         end
      join
      check("R10 second tx byte", b, 8'h0F);
      tick(5);
      check("R10 SDA free after nack", sda_oe, 0);
      check("R10 SCL free after nack", scl_oe, 0);
      bus_stop;

      // R11 status writes
      reg_rd(3'd6, s0);
      reg_wr(3'd6, 8'hFF);
      reg_rd(3'd6, d);
      check("R11 upper bits written", d[7:6], 2'b11);
      check("R11 lower bits kept", d[5:0], s0[5:0]);
      check("R11 irq follows flag", irq, 1);
      reg_wr(3'd6, 8'h00);
      tick(1);
      check("R11 irq cleared", irq, 0);

      // R12 disabled
      reg_wr(3'd5, 8'h00);
      bus_start;
      write_byte(8'hA0, ak); check("R12 no ack when off", ak, 0);
      check("R12 SDA untouched", sda_oe, 0);
      bus_stop;

      check("scoreboard empty", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule